// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Controller

This block sits beside a small UART whose receive and transmit FIFOs each hold eight characters. It holds one 8-bit control register. That register exports the receiver and transmitter enables. It also selects how the external RTS and CTS handshake lines are handled.

In automatic RTS mode, RTS is derived from the receive FIFO fill level. RTS stays at its ready level while more free slots remain than a selectable threshold. In software mode, RTS follows a separate software bit. In automatic CTS mode, the external CTS line passes through a two-flop synchronizer and gates the transmit-permit output. The transmitter samples that output only when it is about to start a new character, so a character already being shifted out always completes. RTS and CTS each have their own polarity-invert bit.

The register is written through a single-cycle port. Its value is always visible on the read-data output.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x03, `rx_enable` and `tx_enable` are 1, `rts_out` is 0 and `tx_permit` is 1.
- R2: A write with `reg_wr_en` high takes effect at that clock edge. `reg_rd_data` then returns all 8 written bits unchanged. Bit 0 drives `rx_enable` and bit 1 drives `tx_enable`.
- R3: With bit 2 (automatic RTS) and bit 0 set, the ready level is computed from free = 8 − `rx_level` (0 when `rx_level` ≥ 8). The ready level is 1 while free exceeds the threshold and 0 otherwise, and it appears on `rts_out` one clock edge after the inputs are sampled.
- R4: Bits 5:4 select the threshold in free slots: code 0 gives 3, code 1 gives 2, code 2 gives 1 and code 3 gives 4.
- R5: Bit 6 inverts `rts_out` in automatic RTS mode only.
- R6: With bit 2 clear and bit 0 set, `rts_out` equals `sw_rts` as sampled at the previous clock edge, with no inversion.
- R7: With bit 0 clear, `rts_out` goes to its not-ready level whatever the fill level is. That level is 1 when bits 2 and 6 are both set, and 0 otherwise.
- R8: With bit 3 (automatic CTS) and bit 1 set, `tx_permit` follows the effective CTS value. A change on `cts_in` that is set up before a rising edge reaches `tx_permit` after the second rising edge.
- R9: CTS high means clear to send. Bit 7 inverts the synchronized CTS before it gates `tx_permit`.
- R10: With bit 3 clear, `tx_permit` equals bit 1, and `cts_in` has no effect on it.
- R11: With bit 1 clear, `tx_permit` is 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write data |
| reg_rd_data | output | 8 | Current control register value |
| rx_level | input | 4 | Receive FIFO fill level, 0 to 8 |
| sw_rts | input | 1 | Software RTS value used when automatic RTS is off |
| cts_in | input | 1 | External CTS line, asynchronous |
| rts_out | output | 1 | External RTS line, registered |
| tx_permit | output | 1 | Transmitter may start a new character |
| rx_enable | output | 1 | Receiver enable (register bit 0) |
| tx_enable | output | 1 | Transmitter enable (register bit 1) |

## Verification
The bench sweeps the fill level from empty to full under all four threshold codes. A decoder that assumed a monotonic code order, or that used ≥ instead of > at the boundary, would move the RTS release point by one slot and be caught at the exact level where it differs.

CTS pulses of one, two and several cycles check the two-stage latency. A shortened or lengthened synchronizer would shift `tx_permit` by a cycle.

Each polarity bit is exercised with the other mode active, which exposes inversion applied to the wrong line or in software mode. Clearing the receiver enable with inversion on and off checks that the forced not-ready level follows the polarity rule rather than a fixed 0.

// File: rtl/uafc_pkg.sv
// Shared types and decode helpers for the UART flow controller.
// Assumes a control register of exactly eight bits with the field
// order below; bit positions are software-visible and must not move.
package uafc_pkg;

    // Control register fields, MSB first
    typedef struct packed {
        logic       cts_inv;   // bit 7
        logic       rts_inv;   // bit 6
        logic [1:0] rts_thr;   // bits 5:4
        logic       auto_cts;  // bit 3
        logic       auto_rts;  // bit 2
        logic       tx_en;     // bit 1
        logic       rx_en;     // bit 0
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h03;

    // Map the 2-bit threshold code to a free-slot count (not monotonic)
    function automatic logic [2:0] thr_slots(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd3;
            2'd1:    return 3'd2;
            2'd2:    return 3'd1;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/uafc_ctrl_reg.sv
// Control register for the flow controller.
// Holds the 8-bit configuration word; a write is accepted on the
// clock edge where wr_en is high. Assumes a synchronous active-low reset.
module uafc_ctrl_reg
    import uafc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output ctrl_t      ctrl_q
);

    // Load the register on reset or on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= ctrl_t'(CTRL_RESET);
        end else if (wr_en) begin
            ctrl_q <= ctrl_t'(wr_data);
        end
    end

endmodule

// File: rtl/uafc_cts_sync.sv
// Multi-flop synchronizer for the asynchronous CTS line.
// STAGES flops in series; output is the last stage. Assumes STAGES >= 2
// and a synchronous active-low reset to RESET_VAL.
module uafc_cts_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // First stage captures the raw line
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= RESET_VAL;
        else        chain_q[0] <= async_in;
    end

    // Remaining stages shift the value along
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= RESET_VAL;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/uafc_rts_gen.sv
// RTS generator: picks between the software bit and the fill-level
// threshold compare, applies polarity in automatic mode, forces the
// not-ready level when the receiver is disabled, and registers the pin.
// Assumes rx_level never exceeds FIFO_DEPTH (larger values read as full).
module uafc_rts_gen
    import uafc_pkg::*;
#(
    parameter  int FIFO_DEPTH = 8,
    parameter  int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             sw_rts,
    output logic             rts_q
);

    localparam logic [LVL_W-1:0] DEPTH_V = LVL_W'(FIFO_DEPTH);

    logic [LVL_W-1:0] free_slots;
    logic [LVL_W-1:0] thr_v;
    logic             auto_ready;
    logic             rts_d;

    // Free receive slots, saturating at zero
    always_comb begin
        if (rx_level >= DEPTH_V) free_slots = '0;
        else                     free_slots = DEPTH_V - rx_level;
    end

    // Threshold compare: ready while strictly more slots than threshold
    always_comb begin
        thr_v      = LVL_W'(thr_slots(ctrl.rts_thr));
        auto_ready = (free_slots > thr_v);
    end

    // Select the next pin level by mode and receiver enable
    always_comb begin
        if (ctrl.auto_rts) begin
            rts_d = (ctrl.rx_en ? auto_ready : 1'b0) ^ ctrl.rts_inv;
        end else begin
            rts_d = ctrl.rx_en & sw_rts;
        end
    end

    // Register the pin so it never glitches
    always_ff @(posedge clk) begin
        if (!rst_n) rts_q <= 1'b0;
        else        rts_q <= rts_d;
    end

endmodule

// File: rtl/uart_flow_ctrl.sv
// UART automatic RTS/CTS flow controller (top).
// Combines the control register, the CTS synchronizer and the RTS
// generator, and forms the transmit permit. The transmitter is assumed
// to sample tx_permit only when starting a new character.
module uart_flow_ctrl
    import uafc_pkg::*;
#(
    parameter  int FIFO_DEPTH  = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [7:0]       reg_wr_data,
    output logic [7:0]       reg_rd_data,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             sw_rts,
    input  logic             cts_in,
    output logic             rts_out,
    output logic             tx_permit,
    output logic             rx_enable,
    output logic             tx_enable
);

    ctrl_t ctrl;
    logic  cts_s;

    uafc_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .ctrl_q  (ctrl)
    );

    uafc_cts_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cts_in),
        .sync_out (cts_s)
    );

    uafc_rts_gen #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_rts (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .rx_level (rx_level),
        .sw_rts   (sw_rts),
        .rts_q    (rts_out)
    );

    // Transmit permit: enable gated by effective CTS in automatic mode
    always_comb begin
        tx_permit = ctrl.tx_en & (~ctrl.auto_cts | (cts_s ^ ctrl.cts_inv));
    end

    assign reg_rd_data = ctrl;
    assign rx_enable   = ctrl.rx_en;
    assign tx_enable   = ctrl.tx_en;

endmodule

// File: rtl/uafc_flow_chk.sv
// Checker for uart_flow_ctrl, attached by bind. Observes ports only.
module uafc_flow_chk #(
    parameter int FIFO_DEPTH = 8,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [7:0]       reg_wr_data,
    input logic [7:0]       reg_rd_data,
    input logic [LVL_W-1:0] rx_level,
    input logic             sw_rts,
    input logic             rts_out,
    input logic             tx_permit,
    input logic             tx_enable
);

    localparam logic [LVL_W-1:0] FULL_V = LVL_W'(FIFO_DEPTH);

    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> reg_rd_data == $past(reg_wr_data));

    assert_full_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[0] && reg_rd_data[2] && rx_level >= FULL_V)
        |=> rts_out == $past(reg_rd_data[6]));

    assert_empty_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[0] && reg_rd_data[2] && rx_level == '0)
        |=> rts_out == !$past(reg_rd_data[6]));

    assert_sw_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[0] && !reg_rd_data[2]) |=> rts_out == $past(sw_rts));

    assert_rx_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_data[0] |=> rts_out == $past(reg_rd_data[2] && reg_rd_data[6]));

    assert_cts_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && !reg_rd_data[3]) |-> tx_permit);

    assert_tx_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |-> !tx_permit);

endmodule

bind uart_flow_ctrl uafc_flow_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .rx_level    (rx_level),
    .sw_rts      (sw_rts),
    .rts_out     (rts_out),
    .tx_permit   (tx_permit),
    .tx_enable   (tx_enable)
);

// File: tb/test_uart_flow_ctrl.sv
`timescale 1ns/1ps
module test_uart_flow_ctrl;
    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [7:0]    reg_wr_data = 8'h00;
    logic [7:0]    reg_rd_data;
    logic [LW-1:0] rx_level = '0;
    logic          sw_rts = 1'b0;
    logic          cts_in = 1'b0;
    logic          rts_out, tx_permit, rx_enable, tx_enable;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    cmp_on = 0;
    string phase_tag = "R1";

    always #2.5 clk = ~clk;

    uart_flow_ctrl #(.FIFO_DEPTH(DEPTH)) i_uart_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .rx_level(rx_level), .sw_rts(sw_rts),
        .cts_in(cts_in), .rts_out(rts_out), .tx_permit(tx_permit),
        .rx_enable(rx_enable), .tx_enable(tx_enable)
    );

    // Behavioural reference model
    int m_reg = 3;
    bit m_s1 = 0, m_s2 = 0, m_rts = 0;

    function automatic int slots_for(int code);
        case (code)
            0: return 3;
            1: return 2;
            2: return 1;
            default: return 4;
        endcase
    endfunction

    function automatic bit rts_next();
        int  free;
        bit  ready;
        if ((m_reg & 4) == 0) return ((m_reg & 1) != 0) ? sw_rts : 1'b0;
        if ((m_reg & 1) == 0) return ((m_reg >> 6) & 1) != 0;
        free  = (int'(rx_level) >= DEPTH) ? 0 : DEPTH - int'(rx_level);
        ready = free > slots_for((m_reg >> 4) & 3);
        return ready ^ (((m_reg >> 6) & 1) != 0);
    endfunction

    function automatic bit permit_exp();
        bit txen = (m_reg & 2) != 0;
        bit acts = (m_reg & 8) != 0;
        bit inv  = (m_reg & 128) != 0;
        return txen && (!acts || (m_s2 ^ inv));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg <= 3; m_s1 <= 0; m_s2 <= 0; m_rts <= 0;
        end else begin
            m_rts <= rts_next();
            m_s1  <= cts_in;
            m_s2  <= m_s1;
            if (reg_wr_en) m_reg <= int'(reg_wr_data);
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R2", "reg_rd_data", int'(reg_rd_data), m_reg);
            check("R2", "rx_enable", int'(rx_enable), m_reg & 1);
            check("R2", "tx_enable", int'(tx_enable), (m_reg >> 1) & 1);
            check(phase_tag, "rts_out", int'(rts_out), int'(m_rts));
            check(phase_tag, "tx_permit", int'(tx_permit), int'(permit_exp()));
        end
    end

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] v);
        @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = v;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    initial begin
        step(3);
        cmp_on = 1;
        rst_n = 1'b1;
        step(1);
        // R1: explicit reset state
        check("R1", "reset reg", int'(reg_rd_data), 3);
        check("R1", "reset rts", int'(rts_out), 0);
        check("R1", "reset permit", int'(tx_permit), 1);
        check("R1", "reset enables", int'({rx_enable, tx_enable}), 3);

        // R6: software RTS follows sw_rts
        phase_tag = "R6";
        for (int i = 0; i < 6; i++) begin sw_rts = i[0]; step(1 + (i % 2)); end
        rx_level = 4'd8; sw_rts = 1'b1; step(3);
        wr(8'h43); sw_rts = 1'b0; step(3);  // inversion has no effect here

        // R2: readback of all bits
        phase_tag = "R2";
        wr(8'hA5); step(2); wr(8'h5A); step(2); wr(8'hFF); step(2); wr(8'h00); step(2);

        // R3 / R4: threshold sweep for every code
        phase_tag = "R4";
        for (int code = 0; code < 4; code++) begin
            wr(8'(8'h07 | (code << 4)));
            for (int lv = 0; lv <= 8; lv++) begin rx_level = LW'(lv); step(2); end
            for (int lv = 8; lv >= 0; lv--) begin rx_level = LW'(lv); step(1); end
        end
        phase_tag = "R3";
        rx_level = 4'd5; wr(8'h07); step(2); rx_level = 4'd4; step(2);

        // R5: inverted automatic RTS
        phase_tag = "R5";
        for (int code = 0; code < 4; code++) begin
            wr(8'(8'h47 | (code << 4)));
            for (int lv = 0; lv <= 8; lv++) begin rx_level = LW'(lv); step(1); end
        end

        // R7: receiver disabled forces not-ready
        phase_tag = "R7";
        rx_level = 4'd0;
        wr(8'h06); step(3); wr(8'h46); step(3);
        sw_rts = 1'b1; wr(8'h02); step(3); wr(8'h42); step(3);
        wr(8'h47); step(2);

        // R8: automatic CTS with synchronizer latency
        phase_tag = "R8";
        cts_in = 1'b0; wr(8'h0B); step(3);
        cts_in = 1'b1; step(1); cts_in = 1'b0; step(3);
        cts_in = 1'b1; step(2); cts_in = 1'b0; step(2);
        cts_in = 1'b1; step(5); cts_in = 1'b0; step(4);

        // R9: inverted CTS
        phase_tag = "R9";
        wr(8'h8B); step(3);
        cts_in = 1'b1; step(4); cts_in = 1'b0; step(1); cts_in = 1'b1; step(4);

        // R10: CTS ignored when automatic CTS off
        phase_tag = "R10";
        wr(8'h83); step(1);
        for (int i = 0; i < 6; i++) begin cts_in = ~cts_in; step(1 + i % 3); end
        check("R10", "permit ignores cts", int'(tx_permit), 1);

        // R11: transmitter disabled blocks permit
        phase_tag = "R11";
        cts_in = 1'b1; wr(8'h08); step(4); wr(8'h01); step(3);
        cts_in = 1'b0; wr(8'h89); step(4);
        check("R11", "permit off", int'(tx_permit), 0);

        step(2);
        finish_up();
    end
endmodule